// File: doc/BRIEF.md
# Ones-Count Filtered Content-Addressable Search

The block is a small content-addressable store that answers "which entry holds this word?" in two pipelined steps. Next to every stored word it keeps a short tag: the number of one bits in that word. The tag is computed by an adder tree when the word is written. A search computes the same tag from the key and compares it against every stored tag at once. Only the entries whose tag agrees with the key's tag are then compared bit for bit against the full key. An entry whose tag differs cannot hold the key, so its wide comparator stays idle for that search.

A search strobe is sampled on a clock edge. The tag filter result is registered on that edge. The full-word compare and the priority pick are registered on the next edge. The outputs report whether any entry matched, the lowest matching index and how many entries passed the filter and were compared in full. Entries are written through a simple write port that can also clear an entry's valid flag. An entry that is not valid takes part in neither step.

Top module: `pcam_search`

## Requirements
- R1: After reset no entry is valid, and valid_o, hit_o, hit_addr_o and cmp_count_o are all zero.
- R2: A write with wr_en_i=1 stores wr_data_i at wr_addr_i and sets the entry valid when wr_valid_i=1. It clears the entry's valid flag when wr_valid_i=0.
- R3: When search_i is sampled high at a clock edge, valid_o is high for exactly one cycle after the following edge, that is two cycles after the strobe is applied.
- R4: If one or more valid entries equal key_i, hit_o=1 and hit_addr_o is the lowest such index.
- R5: cmp_count_o equals the number of valid entries whose stored ones-count equals the ones-count of key_i.
- R6: When no valid entry has the key's ones-count, the result is a miss with cmp_count_o=0.
- R7: Entries that are not valid are excluded from the count and from matching, even when their stored content equals the key.
- R8: When some tags match but no word does, the result is a miss with nonzero cmp_count_o; on every miss hit_addr_o=0.
- R9: hit_o, hit_addr_o and cmp_count_o hold their last result until the next result is produced.
- R10: Searches issued on consecutive cycles each produce their own result, in issue order, on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe |
| wr_valid_i | input | 1 | Valid flag written with the entry |
| wr_addr_i | input | ADDR_W | Entry index to write |
| wr_data_i | input | WORD_W | Word to store |
| search_i | input | 1 | Search strobe |
| key_i | input | WORD_W | Search key |
| valid_o | output | 1 | Result valid pulse |
| hit_o | output | 1 | A valid entry equals the key |
| hit_addr_o | output | ADDR_W | Lowest matching index, zero on a miss |
| cmp_count_o | output | CNT_W | Entries compared in full in the last search |

## Verification
The bench stores duplicate words with the same ones-count, so a design that picked any match but the lowest would report the wrong index, and a filter that ignored the tag would inflate the count. It searches keys whose ones-count matches stored words that differ from the key, and a design that skipped the full compare would report a false hit there. It also searches keys whose ones-count matches no stored word, where any nonzero count exposes a broken filter. Entries are invalidated and written with the valid flag clear while their content equals the key, so a design that ignored the valid flag would hit or overcount. Back-to-back strobes and idle gaps expose results that come out of order, that are delayed or lost, or that are not held.

// File: rtl/pcam_pkg.sv
package pcam_pkg;
  localparam int unsigned DEF_WORD_W  = 16;
  localparam int unsigned DEF_ENTRIES = 16;

  // width needed to hold values 0..n
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/pcam_popcount.sv
module pcam_popcount #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned PAR_W  = 5
) (
  input  logic [WORD_W-1:0] word_i,
  output logic [PAR_W-1:0]  count_o
);
  localparam int unsigned LEVELS = (WORD_W < 2) ? 0 : $clog2(WORD_W);
  localparam int unsigned LEAVES = 1 << LEVELS;

  for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
    logic [PAR_W-1:0] node [LEAVES >> l];
    if (l == 0) begin : g_leaf
      for (genvar i = 0; i < LEAVES; i++) begin : g_bit
        if (i < WORD_W) begin : g_used
          assign node[i] = PAR_W'(word_i[i]);
        end else begin : g_pad
          assign node[i] = '0;
        end
      end
    end else begin : g_sum
      for (genvar i = 0; i < (LEAVES >> l); i++) begin : g_add
        assign node[i] = g_lvl[l-1].node[2*i] + g_lvl[l-1].node[2*i+1];
      end
    end
  end

  assign count_o = g_lvl[LEVELS].node[0];
endmodule

// File: rtl/pcam_store.sv
module pcam_store #(
  parameter int unsigned WORD_W  = 16,
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned PAR_W   = 5,
  parameter int unsigned ADDR_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [WORD_W-1:0] words_o [ENTRIES],
  output logic [PAR_W-1:0]  pars_o  [ENTRIES],
  output logic [ENTRIES-1:0] vld_o
);
  logic [PAR_W-1:0] wr_par;

  pcam_popcount #(.WORD_W(WORD_W), .PAR_W(PAR_W)) u_wr_pop (
    .word_i (wr_data_i),
    .count_o(wr_par)
  );

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic sel;
    assign sel = wr_en_i && (wr_addr_i == ADDR_W'(e));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        words_o[e] <= '0;
        pars_o[e]  <= '0;
        vld_o[e]   <= 1'b0;
      end else if (sel) begin
        words_o[e] <= wr_data_i;
        pars_o[e]  <= wr_par;
        vld_o[e]   <= wr_valid_i;
      end
    end
  end
endmodule

// File: rtl/pcam_param_filter.sv
module pcam_param_filter #(
  parameter int unsigned WORD_W  = 16,
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned PAR_W   = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               search_i,
  input  logic [WORD_W-1:0]  key_i,
  input  logic [PAR_W-1:0]   pars_i [ENTRIES],
  input  logic [ENTRIES-1:0] vld_i,
  output logic               s1_vld_o,
  output logic [WORD_W-1:0]  s1_key_o,
  output logic [ENTRIES-1:0] s1_en_o
);
  logic [PAR_W-1:0]   key_par;
  logic [ENTRIES-1:0] en_d;

  pcam_popcount #(.WORD_W(WORD_W), .PAR_W(PAR_W)) u_key_pop (
    .word_i (key_i),
    .count_o(key_par)
  );

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign en_d[e] = vld_i[e] && (pars_i[e] == key_par);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld_o <= 1'b0;
      s1_key_o <= '0;
      s1_en_o  <= '0;
    end else begin
      s1_vld_o <= search_i;
      if (search_i) begin
        s1_key_o <= key_i;
        s1_en_o  <= en_d;
      end
    end
  end
endmodule

// File: rtl/pcam_word_match.sv
module pcam_word_match #(
  parameter int unsigned WORD_W  = 16,
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned CNT_W   = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               s1_vld_i,
  input  logic [WORD_W-1:0]  s1_key_i,
  input  logic [ENTRIES-1:0] s1_en_i,
  input  logic [WORD_W-1:0]  words_i [ENTRIES],
  output logic               valid_o,
  output logic               hit_o,
  output logic [ADDR_W-1:0]  hit_addr_o,
  output logic [CNT_W-1:0]   cmp_count_o
);
  logic [ENTRIES-1:0] match;
  logic [ADDR_W-1:0]  pick;
  logic [CNT_W-1:0]   en_cnt;

  // full compare only on entries that passed the tag filter
  for (genvar e = 0; e < ENTRIES; e++) begin : g_full
    assign match[e] = s1_en_i[e] && (words_i[e] == s1_key_i);
  end

  always_comb begin
    pick = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (match[e]) pick = ADDR_W'(e);
    end
  end

  always_comb begin
    en_cnt = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      en_cnt = en_cnt + CNT_W'(s1_en_i[e]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      hit_o       <= 1'b0;
      hit_addr_o  <= '0;
      cmp_count_o <= '0;
    end else begin
      valid_o <= s1_vld_i;
      if (s1_vld_i) begin
        hit_o       <= |match;
        hit_addr_o  <= pick;
        cmp_count_o <= en_cnt;
      end
    end
  end
endmodule

// File: rtl/pcam_search.sv
module pcam_search #(
  parameter int unsigned WORD_W  = pcam_pkg::DEF_WORD_W,
  parameter int unsigned ENTRIES = pcam_pkg::DEF_ENTRIES,
  parameter int unsigned ADDR_W  = (ENTRIES < 2) ? 1 : $clog2(ENTRIES),
  parameter int unsigned CNT_W   = pcam_pkg::cnt_width(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              search_i,
  input  logic [WORD_W-1:0] key_i,
  output logic              valid_o,
  output logic              hit_o,
  output logic [ADDR_W-1:0] hit_addr_o,
  output logic [CNT_W-1:0]  cmp_count_o
);
  localparam int unsigned PAR_W = pcam_pkg::cnt_width(WORD_W);

  logic [WORD_W-1:0]  words [ENTRIES];
  logic [PAR_W-1:0]   pars  [ENTRIES];
  logic [ENTRIES-1:0] vld;
  logic               s1_vld;
  logic [WORD_W-1:0]  s1_key;
  logic [ENTRIES-1:0] s1_en;

  pcam_store #(
    .WORD_W(WORD_W), .ENTRIES(ENTRIES), .PAR_W(PAR_W), .ADDR_W(ADDR_W)
  ) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_valid_i(wr_valid_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .words_o   (words),
    .pars_o    (pars),
    .vld_o     (vld)
  );

  pcam_param_filter #(
    .WORD_W(WORD_W), .ENTRIES(ENTRIES), .PAR_W(PAR_W)
  ) u_filter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .search_i(search_i),
    .key_i   (key_i),
    .pars_i  (pars),
    .vld_i   (vld),
    .s1_vld_o(s1_vld),
    .s1_key_o(s1_key),
    .s1_en_o (s1_en)
  );

  pcam_word_match #(
    .WORD_W(WORD_W), .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) u_match (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .s1_vld_i   (s1_vld),
    .s1_key_i   (s1_key),
    .s1_en_i    (s1_en),
    .words_i    (words),
    .valid_o    (valid_o),
    .hit_o      (hit_o),
    .hit_addr_o (hit_addr_o),
    .cmp_count_o(cmp_count_o)
  );
endmodule

// File: rtl/pcam_search_chk.sv
module pcam_search_chk #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned CNT_W   = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              search_i,
  input logic              valid_o,
  input logic              hit_o,
  input logic [ADDR_W-1:0] hit_addr_o,
  input logic [CNT_W-1:0]  cmp_count_o
);
  assert_result_latency_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    search_i |-> ##2 valid_o);

  assert_no_spurious_result_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(search_i, 2));

  assert_hit_needs_compare_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && hit_o) |-> (cmp_count_o != '0));

  assert_count_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (cmp_count_o <= CNT_W'(ENTRIES)));

  assert_miss_addr_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !hit_o) |-> (hit_addr_o == '0));

  assert_result_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(hit_o) && $stable(hit_addr_o) && $stable(cmp_count_o)));
endmodule

bind pcam_search pcam_search_chk #(
  .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .search_i   (search_i),
  .valid_o    (valid_o),
  .hit_o      (hit_o),
  .hit_addr_o (hit_addr_o),
  .cmp_count_o(cmp_count_o)
);

// File: tb/pcam_search_bench.sv
`timescale 1ns/1ps
module pcam_search_bench;
  localparam int unsigned WORD_W  = 16;
  localparam int unsigned ENTRIES = 16;
  localparam int unsigned ADDR_W  = 4;
  localparam int unsigned CNT_W   = 5;

  typedef struct {
    logic              hit;
    logic [ADDR_W-1:0] addr;
    logic [CNT_W-1:0]  cnt;
    int                issue;
    string             tag;
  } exp_t;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              wr_en_i = 1'b0;
  logic              wr_valid_i = 1'b0;
  logic [ADDR_W-1:0] wr_addr_i = '0;
  logic [WORD_W-1:0] wr_data_i = '0;
  logic              search_i = 1'b0;
  logic [WORD_W-1:0] key_i = '0;
  logic              valid_o, hit_o;
  logic [ADDR_W-1:0] hit_addr_o;
  logic [CNT_W-1:0]  cmp_count_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  exp_t sb_q[$];
  exp_t last_res;
  logic [WORD_W-1:0] m_word [ENTRIES];
  logic              m_vld  [ENTRIES];

  always #10 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  pcam_search u_pcam_search (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(wr_en_i), .wr_valid_i(wr_valid_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .search_i(search_i), .key_i(key_i),
    .valid_o(valid_o), .hit_o(hit_o),
    .hit_addr_o(hit_addr_o), .cmp_count_o(cmp_count_o)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic write(input int a, input logic [WORD_W-1:0] d, input logic v);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_valid_i = v; wr_addr_i = ADDR_W'(a); wr_data_i = d;
    m_word[a] = d; m_vld[a] = v;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  // drive one strobe at the current negedge and push the expected result
  task automatic issue(input logic [WORD_W-1:0] k, input string tag);
    exp_t e;
    e.hit = 1'b0; e.addr = '0; e.cnt = '0; e.issue = cyc; e.tag = tag;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (m_vld[i] && $countones(m_word[i]) == $countones(k)) e.cnt = e.cnt + 1'b1;
      if (m_vld[i] && m_word[i] == k) begin e.hit = 1'b1; e.addr = ADDR_W'(i); end
    end
    search_i = 1'b1; key_i = k;
    sb_q.push_back(e);
  endtask

  task automatic search(input logic [WORD_W-1:0] k, input string tag);
    @(negedge clk_i);
    issue(k, tag);
    @(negedge clk_i);
    search_i = 1'b0;
    repeat (2) @(negedge clk_i);
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni && valid_o) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R3", "unexpected valid_o", 1, 0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(cyc == e.issue + 2, "R3", {e.tag, " latency"}, cyc - e.issue, 2);
        check(hit_o == e.hit, e.tag, "hit_o", int'(hit_o), int'(e.hit));
        check(hit_addr_o == e.addr, e.tag, "hit_addr_o", int'(hit_addr_o), int'(e.addr));
        check(cmp_count_o == e.cnt, e.tag, "cmp_count_o", int'(cmp_count_o), int'(e.cnt));
        last_res = e;
      end
    end
  end

  initial begin
    #(20 * 150000);
    check(1'b0, "watchdog", "timeout", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < ENTRIES; i++) begin m_word[i] = '0; m_vld[i] = 1'b0; end
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check(valid_o == 1'b0, "R1", "valid_o", int'(valid_o), 0);
    check(hit_o == 1'b0, "R1", "hit_o", int'(hit_o), 0);
    check(hit_addr_o == '0, "R1", "hit_addr_o", int'(hit_addr_o), 0);
    check(cmp_count_o == '0, "R1", "cmp_count_o", int'(cmp_count_o), 0);
    rst_ni = 1'b1;
    search(16'h0000, "R1");               // empty: zero-valued stale entries must not hit

    write(0, 16'h00FF, 1'b1);             // R2 eight ones
    write(1, 16'h0F0F, 1'b1);
    write(2, 16'h1234, 1'b1);             // five ones
    write(3, 16'hFFFF, 1'b1);
    write(4, 16'h0000, 1'b1);
    write(5, 16'h00FF, 1'b1);             // duplicate of entry 0
    write(6, 16'hF000, 1'b1);
    write(15, 16'hA5A5, 1'b1);            // top index

    search(16'h0F0F, "R2");
    search(16'h00FF, "R4");               // lowest of 0 and 5
    search(16'h1234, "R5");
    search(16'hFF00, "R8");               // tags agree, words differ
    search(16'h0001, "R6");               // no tag agrees
    search(16'hFFFF, "R4");
    search(16'hA5A5, "R4");
    search(16'h0000, "R5");

    write(0, 16'h00FF, 1'b0);             // invalidate
    search(16'h00FF, "R7");               // now entry 5
    write(7, 16'h0001, 1'b0);             // stored but not valid
    search(16'h0001, "R7");
    write(5, 16'h0000, 1'b0);
    search(16'h00FF, "R7");               // tag count drops

    // R10 back-to-back
    @(negedge clk_i); issue(16'h0F0F, "R10");
    @(negedge clk_i); issue(16'h1234, "R10");
    @(negedge clk_i); issue(16'h0001, "R10");
    @(negedge clk_i); issue(16'hFFFF, "R10");
    @(negedge clk_i); search_i = 1'b0;
    repeat (4) @(negedge clk_i);

    // R9 hold after the last result
    repeat (3) begin
      @(negedge clk_i);
      check(valid_o == 1'b0, "R9", "valid_o idle", int'(valid_o), 0);
      check(hit_o == last_res.hit, "R9", "hit_o held", int'(hit_o), int'(last_res.hit));
      check(hit_addr_o == last_res.addr, "R9", "hit_addr_o held",
            int'(hit_addr_o), int'(last_res.addr));
      check(cmp_count_o == last_res.cnt, "R9", "cmp_count_o held",
            int'(cmp_count_o), int'(last_res.cnt));
    end
    check(sb_q.size() == 0, "R10", "results outstanding", sb_q.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule